// File: doc/BRIEF.md
# Banked Shared Memory Conflict Arbiter

This block is a scratchpad made of 16 word-wide banks that serves one group of 16 lane requests at a time. Each lane brings an enable, a read/write flag, a word address and write data. Words are interleaved across the banks, so neighbouring words sit in neighbouring banks. Every bank serves one word per cycle. The block therefore finishes a group in as many cycles as its busiest bank needs. Lanes that name the same word are all served in the cycle that word is served. For reads this is a broadcast.

A request is offered with `req_valid` while the block is idle. The block then works through the pending lanes. In each cycle, every bank takes its lowest-numbered pending lane together with all other pending lanes on that same word. When nothing is left, `done` pulses for one cycle. At that point the read data of every read lane is on `rd_data` and the number of service cycles is on `cycles`. A new request is not taken while the block is busy.

Top module: `bank_arb_smem`

## Requirements
- R1: A word address selects bank `addr[3:0]` (address modulo 16) and row `addr[AW-1:4]` inside that bank.
- R2: A group whose enabled lanes all fall in different banks is served in one cycle (`cycles` = 1), for example stride 1 or any odd stride.
- R3: A group whose lanes all read one identical word is served in one cycle, and every lane receives that word.
- R4: Otherwise `cycles` equals the largest number of distinct words that any single bank must supply (stride 2 gives 2, stride 8 gives 8, stride 16 gives 16).
- R5: A reading lane receives the content its word had before the group started, even when other lanes of the same group write that word.
- R6: When several lanes of one group write the same word, the data of the highest-numbered writing lane is stored.
- R7: After acceptance, `busy` stays high for max(`cycles`,1) cycles. `done` is then high for exactly one cycle, with `busy` low, `cycles` valid and `rd_data` valid for the read lanes.
- R8: `req_valid` asserted while `busy` is high is ignored. It stores nothing and does not change the results of the current group.
- R9: A request with no enabled lane finishes after one busy cycle with `cycles` = 0.
- R10: After reset, `busy`, `done`, `cycles` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Offer a lane group; taken when `busy` is low |
| lane_en | input | LANES | Per-lane request enable |
| lane_we | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | LANES*AW | Per-lane word address, lane l at bits [l*AW +: AW] |
| lane_wdata | input | LANES*DW | Per-lane write data, lane l at bits [l*DW +: DW] |
| busy | output | 1 | A group is being served |
| done | output | 1 | One-cycle pulse when the group is finished |
| cycles | output | $clog2(LANES+1) | Service cycles used by the last group |
| rd_data | output | LANES*DW | Per-lane read data, lane l at bits [l*DW +: DW] |

## Verification
The hardest cases to reach from the ports are those where reads and writes to one word share a group, and where requests arrive while the block is still busy with an earlier group. The stimulus first fills every word with a known pattern. It then issues groups in which half the lanes write a word that the other half reads. It also keeps `req_valid` high with write-everything data during a 16-cycle worst-case group. Afterwards it reads back the words those ignored writes would have touched. Stride sweeps (1, 2, 3, 8, 16), a full broadcast, sparse enables and an empty group cover the range of conflict degrees.

// File: rtl/smem_pkg.sv
package smem_pkg;
  function automatic int unsigned cnt_width(input int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/bank_pick.sv
module bank_pick #(
  parameter int LANES   = 16,
  parameter int BANKS   = 16,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    we,
  input  logic [LANES*DW-1:0] wdata,
  output logic                act,
  output logic [AW-1:0]       sel_addr,
  output logic [LANES-1:0]    grp,
  output logic                wr_en,
  output logic [DW-1:0]       wr_dat
);
  localparam int BW = $clog2(BANKS);

  always_comb begin
    act      = 1'b0;
    sel_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!act && pend[l] && (addr[l*AW +: BW] == BW'(BANK_ID))) begin
        act      = 1'b1;
        sel_addr = addr[l*AW +: AW];
      end
    end
  end

  always_comb begin
    grp    = '0;
    wr_en  = 1'b0;
    wr_dat = '0;
    for (int l = 0; l < LANES; l++) begin
      grp[l] = act && pend[l] && (addr[l*AW +: AW] == sel_addr);
      if (grp[l] && we[l]) begin
        wr_en  = 1'b1;
        wr_dat = wdata[l*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int RW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/bank_arb_smem.sv
module bank_arb_smem
  import smem_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [LANES-1:0]    lane_en,
  input  logic [LANES-1:0]    lane_we,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*DW-1:0] lane_wdata,
  output logic                busy,
  output logic                done,
  output logic [CW-1:0]       cycles,
  output logic [LANES*DW-1:0] rd_data
);
  localparam int BW    = $clog2(BANKS);
  localparam int DEPTH = (1 << AW) / BANKS;
  localparam int RW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0]    pend_r, we_r;
  logic [LANES*AW-1:0] addr_r;
  logic [LANES*DW-1:0] wdata_r;
  logic [CW-1:0]       cnt_r;
  logic [DW-1:0]       rd_r [LANES];

  logic [LANES-1:0] grp_b   [BANKS];
  logic [DW-1:0]    bank_rd [BANKS];
  logic [LANES-1:0] served;
  logic [LANES-1:0] pend_nxt;
  logic [CW-1:0]    cnt_nxt;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          act, wr_en;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] wr_dat;

    bank_pick #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW), .BANK_ID(b)) pick_i (
      .pend(pend_r), .addr(addr_r), .we(we_r), .wdata(wdata_r),
      .act(act), .sel_addr(sel_addr), .grp(grp_b[b]),
      .wr_en(wr_en), .wr_dat(wr_dat)
    );

    bank_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
      .clk(clk), .we(wr_en && busy), .row(RW'(sel_addr >> BW)),
      .wdata(wr_dat), .rdata(bank_rd[b])
    );

    AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> act);  // R6
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | grp_b[b];
  end

  assign pend_nxt = pend_r & ~served;
  assign cnt_nxt  = cnt_r + CW'(|pend_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cycles  <= '0;
      cnt_r   <= '0;
      pend_r  <= '0;
      we_r    <= '0;
      addr_r  <= '0;
      wdata_r <= '0;
      for (int l = 0; l < LANES; l++) rd_r[l] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          pend_r  <= lane_en;
          we_r    <= lane_we;
          addr_r  <= lane_addr;
          wdata_r <= lane_wdata;
          cnt_r   <= '0;
        end
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (served[l] && !we_r[l]) rd_r[l] <= bank_rd[addr_r[l*AW +: BW]];
        end
        pend_r <= pend_nxt;
        cnt_r  <= cnt_nxt;
        if (pend_nxt == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          cycles <= cnt_nxt;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign rd_data[l*DW +: DW] = rd_r[l];
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R7
  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles <= CW'(LANES)));  // R4
  AST_PROGRESS: assert property (@(posedge clk) disable iff (rst)
    (busy && |pend_r) |=> ($countones(pend_r) < $countones($past(pend_r))));  // R4
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));  // R8
endmodule

// File: tb/bank_arb_smem_tb_top.sv
module bank_arb_smem_tb_top;
  localparam int LANES = 16;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int CW    = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [LANES-1:0]    lane_en = '0, lane_we = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic [LANES*DW-1:0] lane_wdata = '0;
  logic busy, done;
  logic [CW-1:0] cycles;
  logic [LANES*DW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  int ticks = 0;

  logic [DW-1:0] ref_mem [256];
  logic [AW-1:0] a_v [LANES];
  logic [DW-1:0] d_v [LANES];
  logic [LANES-1:0] en_v, we_v;

  always #10 clk = ~clk;

  bank_arb_smem #(.LANES(LANES), .BANKS(16), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .lane_en(lane_en),
    .lane_we(lane_we), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .busy(busy), .done(done), .cycles(cycles), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", ticks);
      finish_run();
    end
  end

  // issue the group held in a_v/d_v/en_v/we_v; noisy keeps req_valid high while busy
  task automatic run_group(input string req, input bit noisy);
    int exp_cyc, nb, k;
    logic [DW-1:0] exp_rd [LANES];
    exp_cyc = 0;
    for (int b = 0; b < 16; b++) begin
      nb = 0;
      for (int l = 0; l < LANES; l++) begin
        bit seen = 0;
        if (!en_v[l] || (a_v[l] % 16) != b) continue;
        for (int m = 0; m < l; m++)
          if (en_v[m] && a_v[m] == a_v[l]) seen = 1;
        if (!seen) nb++;
      end
      if (nb > exp_cyc) exp_cyc = nb;
    end
    for (int l = 0; l < LANES; l++) exp_rd[l] = ref_mem[a_v[l]];
    for (int l = 0; l < LANES; l++)
      if (en_v[l] && we_v[l]) ref_mem[a_v[l]] = d_v[l];
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l*AW +: AW]  = a_v[l];
      lane_wdata[l*DW +: DW] = d_v[l];
    end
    lane_en   = en_v;
    lane_we   = we_v;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = (exp_cyc < 1) ? 1 : exp_cyc;
    for (int i = 0; i < k; i++) begin
      chk({req, " R7 busy"}, 64'(busy), 64'd1);
      chk({req, " R7 no early done"}, 64'(done), 64'd0);
      if (noisy) begin
        req_valid = 1'b1;
        lane_en   = '1;
        lane_we   = '1;
        for (int l = 0; l < LANES; l++) begin
          lane_addr[l*AW +: AW]  = AW'(l);
          lane_wdata[l*DW +: DW] = 32'hDEAD_0000 | l;
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk({req, " R7 done"}, 64'(done), 64'd1);
    chk({req, " R7 idle at done"}, 64'(busy), 64'd0);
    chk({req, " cycles"}, 64'(cycles), 64'(exp_cyc));
    for (int l = 0; l < LANES; l++)
      if (en_v[l] && !we_v[l])
        chk({req, " R5 read data"}, 64'(rd_data[l*DW +: DW]), 64'(exp_rd[l]));
    @(negedge clk);
    chk({req, " R7 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic set_reads(input int base, input int stride);
    for (int l = 0; l < LANES; l++) begin
      a_v[l] = AW'(base + stride * l);
      d_v[l] = '0;
    end
    en_v = '1;
    we_v = '0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 cycles", 64'(cycles), 64'd0);
    chk("R10 rd_data", 64'(rd_data[63:0]), 64'd0);

    // fill every word: stride-1 writes, one cycle each (R1, R2)
    for (int g = 0; g < 16; g++) begin
      for (int l = 0; l < LANES; l++) begin
        a_v[l] = AW'(g * 16 + l);
        d_v[l] = pat(g * 16 + l);
      end
      en_v = '1;
      we_v = '1;
      run_group("R1 R2 fill", 1'b0);
    end

    set_reads(8'h20, 1);  run_group("R2 stride1", 1'b0);
    set_reads(8'h07, 3);  run_group("R2 R1 stride3", 1'b0);
    set_reads(8'h00, 2);  run_group("R4 stride2", 1'b0);
    set_reads(8'h03, 8);  run_group("R4 stride8", 1'b0);
    set_reads(8'h05, 16); run_group("R4 stride16", 1'b0);
    set_reads(8'h55, 0);  run_group("R3 broadcast", 1'b0);

    // two words in bank 5, alternating lanes: 2 cycles
    set_reads(0, 0);
    for (int l = 0; l < LANES; l++) a_v[l] = (l % 2) ? 8'h15 : 8'h05;
    run_group("R4 R3 two words one bank", 1'b0);

    // all lanes write one word: highest lane wins
    for (int l = 0; l < LANES; l++) begin
      a_v[l] = 8'h40;
      d_v[l] = 32'hA000_0000 + l;
    end
    en_v = '1;
    we_v = '1;
    run_group("R6 write merge", 1'b0);
    set_reads(8'h40, 0);  run_group("R6 readback", 1'b0);

    // half write, half read the same word: reads see old content
    for (int l = 0; l < LANES; l++) begin
      a_v[l] = 8'h41;
      d_v[l] = 32'hB000_0000 + l;
    end
    en_v = '1;
    we_v = 16'h00FF;
    run_group("R5 R6 mixed", 1'b0);
    set_reads(8'h41, 0);  run_group("R5 R6 readback", 1'b0);

    // sparse enables, same bank, different words
    set_reads(0, 0);
    a_v[3] = 8'h12;
    a_v[9] = 8'h72;
    en_v = 16'h0208;
    run_group("R4 sparse", 1'b0);

    // empty group
    set_reads(0, 0);
    en_v = '0;
    run_group("R9 empty", 1'b0);

    // requests while busy must be ignored
    set_reads(8'h06, 16); run_group("R8 noisy", 1'b1);
    set_reads(8'h00, 1);  run_group("R8 untouched", 1'b0);

    finish_run();
  end
endmodule